// File: doc/BRIEF.md
# AXI4 Per-Beat Data Throttle Shim

This block sits between an AXI4 master and a memory slave and slows both data channels down one beat at a time. The address channels, the write response channel and all IDs go straight through. Each data beat is taken from its source side into a holding register. The shim then keeps both the VALID toward the sink and the READY toward the source low for a fixed stall of 15 clock cycles. After that it offers the held beat to the sink. Neither side can complete a beat while the window is open. A burst of N beats therefore sees N separate stall windows, not one window per transaction.

A direction becomes armed when its address handshake completes. The stall timer does not start on that handshake, because the time until the first data beat is unknown. It starts when a data beat is actually accepted. The direction disarms when a beat carrying LAST has been delivered to the sink. Only one transaction per direction is in flight at a time, and a new address is held back until the current burst ends. While a beat is held, its data word passes through a modify hook: an XOR with the `DATA_XOR` parameter, where zero leaves the word unchanged. Read ID, read response, write strobes and the LAST flag are held with the word. Bursts can be up to 64 beats of 64-bit data.

Top module: `axi_beat_throttle`

## Requirements
- R1: While a direction is idle, its address channel is forwarded combinationally. The slave-side valid follows the master-side valid, the master-side ready follows the slave-side ready, and address, length and ID are copied unchanged.
- R2: From the cycle after an address handshake until the burst's LAST beat has been delivered, the same direction's address channel is blocked. The slave-side valid and the master-side ready are both low.
- R3: A data beat offered while its direction is not armed is ignored. The source-side ready stays low and the sink-side valid stays low.
- R4: When a beat is accepted on the source side, the next 15 cycles have both the source-side ready and the sink-side valid low. In the 16th cycle after acceptance, the sink-side valid is high.
- R5: While the sink-side valid is high and the sink-side ready is low, the valid, the data, the side fields and the LAST flag stay unchanged.
- R6: The delivered data word equals the accepted word XOR `DATA_XOR`. The write strobes, or the read ID and read response, and the LAST flag are delivered unchanged with it.
- R7: Every beat of a burst gets its own stall window. After the beat with LAST is delivered, the direction disarms, so the source-side ready is low in the next cycle.
- R8: The write response channel is forwarded unchanged in both directions: valid, ready, response and ID.
- R9: Right after reset, both directions are disarmed. The master-side write ready, the slave-side write valid, the slave-side read ready and the master-side read valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_awvalid | input | 1 | Write address valid from master |
| s_awready | output | 1 | Write address ready to master |
| s_awaddr | input | 32 | Write address from master |
| s_awlen | input | 8 | Write burst length minus one from master |
| s_awid | input | 4 | Write ID from master |
| m_awvalid | output | 1 | Write address valid to slave |
| m_awready | input | 1 | Write address ready from slave |
| m_awaddr | output | 32 | Write address to slave |
| m_awlen | output | 8 | Write burst length to slave |
| m_awid | output | 4 | Write ID to slave |
| s_wvalid | input | 1 | Write data valid from master |
| s_wready | output | 1 | Write data ready to master |
| s_wdata | input | 64 | Write data from master |
| s_wstrb | input | 8 | Write byte strobes from master |
| s_wlast | input | 1 | Last write beat flag from master |
| m_wvalid | output | 1 | Write data valid to slave |
| m_wready | input | 1 | Write data ready from slave |
| m_wdata | output | 64 | Held and modified write data to slave |
| m_wstrb | output | 8 | Write byte strobes to slave |
| m_wlast | output | 1 | Last write beat flag to slave |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Write response ready from master |
| s_bresp | output | 2 | Write response code to master |
| s_bid | output | 4 | Write response ID to master |
| m_bvalid | input | 1 | Write response valid from slave |
| m_bready | output | 1 | Write response ready to slave |
| m_bresp | input | 2 | Write response code from slave |
| m_bid | input | 4 | Write response ID from slave |
| s_arvalid | input | 1 | Read address valid from master |
| s_arready | output | 1 | Read address ready to master |
| s_araddr | input | 32 | Read address from master |
| s_arlen | input | 8 | Read burst length minus one from master |
| s_arid | input | 4 | Read ID from master |
| m_arvalid | output | 1 | Read address valid to slave |
| m_arready | input | 1 | Read address ready from slave |
| m_araddr | output | 32 | Read address to slave |
| m_arlen | output | 8 | Read burst length to slave |
| m_arid | output | 4 | Read ID to slave |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Read data ready from master |
| s_rdata | output | 64 | Held and modified read data to master |
| s_rresp | output | 2 | Read response to master |
| s_rid | output | 4 | Read ID to master |
| s_rlast | output | 1 | Last read beat flag to master |
| m_rvalid | input | 1 | Read data valid from slave |
| m_rready | output | 1 | Read data ready to slave |
| m_rdata | input | 64 | Read data from slave |
| m_rresp | input | 2 | Read response from slave |
| m_rid | input | 4 | Read ID from slave |
| m_rlast | input | 1 | Last read beat flag from slave |

## Verification
The table of bursts covers both directions. Burst lengths are a single beat, short bursts and the 64-beat maximum, and the sink either accepts at once or holds ready low for a few cycles. A single beat shows the arm-to-disarm path with no repeated windows. Longer bursts show that every beat, not only the first, gets exactly 15 gated cycles. Backpressure separates holding the beat from dropping or changing it. Each beat uses a word derived from its index and burst, plus its own strobe or response value, so a lost, repeated, reordered or unmasked beat shows up as a mismatch. Directed steps cover data offered before any address, a second address during a burst, and the write response path.

// File: rtl/axi_thr_pkg.sv
package axi_thr_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_TAKE = 2'd1,
    GS_HOLD = 2'd2,
    GS_SEND = 2'd3
  } gate_st_t;
endpackage

// File: rtl/axi_addr_fwd.sv
module axi_addr_fwd #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              block,
  output logic              fire,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [LEN_W-1:0]  s_len,
  input  logic [ID_W-1:0]   s_id,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [LEN_W-1:0]  m_len,
  output logic [ID_W-1:0]   m_id
);
  assign m_valid = s_valid & ~block;
  assign s_ready = m_ready & ~block;
  assign m_addr  = s_addr;
  assign m_len   = s_len;
  assign m_id    = s_id;
  assign fire    = s_valid & s_ready;

  // once an address is taken, the next one must wait for the burst to end
  assert_one_open_R2: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);
  assert_no_slave_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !m_valid);
endmodule

// File: rtl/axi_beat_gate.sv
module axi_beat_gate
  import axi_thr_pkg::*;
#(
  parameter int              DATA_W   = 64,
  parameter int              SIDE_W   = 8,
  parameter int              STALL    = 15,
  parameter logic [DATA_W-1:0] XOR_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  output logic              busy,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic [SIDE_W-1:0] up_side,
  input  logic              up_last,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic [SIDE_W-1:0] dn_side,
  output logic              dn_last
);
  localparam int CW = $clog2(STALL + 1);

  gate_st_t          st;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] dat_q;
  logic [SIDE_W-1:0] side_q;
  logic              last_q;

  assign up_ready = (st == GS_TAKE);
  assign dn_valid = (st == GS_SEND);
  assign busy     = (st != GS_IDLE);
  assign dn_data  = dat_q;
  assign dn_side  = side_q;
  assign dn_last  = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= GS_IDLE;
      cnt    <= '0;
      dat_q  <= '0;
      side_q <= '0;
      last_q <= 1'b0;
    end else begin
      unique case (st)
        GS_IDLE: if (arm) st <= GS_TAKE;
        GS_TAKE: if (up_valid) begin
          dat_q  <= up_data ^ XOR_MASK;
          side_q <= up_side;
          last_q <= up_last;
          cnt    <= CW'(STALL);
          st     <= GS_HOLD;
        end
        GS_HOLD: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= GS_SEND;
        end
        GS_SEND: if (dn_ready) st <= last_q ? GS_IDLE : GS_TAKE;
        default: st <= GS_IDLE;
      endcase
    end
  end

  // independent cycle count since the last acceptance, for the window check
  logic [CW:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst) chk_cnt <= '0;
    else if (up_valid && up_ready) chk_cnt <= '0;
    else if (!dn_valid && chk_cnt != '1) chk_cnt <= chk_cnt + 1'b1;
  end

  assert_gate_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(up_ready && dn_valid));
  assert_stall_len_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_valid) |-> (chk_cnt == (CW+1)'(STALL)));
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) && $stable(dn_side) && $stable(dn_last)));
  assert_disarm_R7: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_ready && dn_last) |=> !up_ready);
endmodule

// File: rtl/axi_beat_throttle.sv
module axi_beat_throttle #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int ID_W      = 4,
  parameter int LEN_W     = 8,
  parameter int STALL_CYC = 15,
  parameter logic [DATA_W-1:0] DATA_XOR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic [ID_W-1:0]   s_awid,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [LEN_W-1:0]  m_awlen,
  output logic [ID_W-1:0]   m_awid,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic              s_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic              m_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  output logic [ID_W-1:0]   s_bid,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp,
  input  logic [ID_W-1:0]   m_bid,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  input  logic [ID_W-1:0]   s_arid,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [LEN_W-1:0]  m_arlen,
  output logic [ID_W-1:0]   m_arid,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic [ID_W-1:0]   s_rid,
  output logic              s_rlast,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic [ID_W-1:0]   m_rid,
  input  logic              m_rlast
);
  localparam int STRB_W  = DATA_W / 8;
  localparam int RSIDE_W = ID_W + 2;

  logic wr_busy, wr_arm, rd_busy, rd_arm;

  axi_addr_fwd #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W)) u_aw (
    .clk(clk), .rst(rst), .block(wr_busy), .fire(wr_arm),
    .s_valid(s_awvalid), .s_ready(s_awready), .s_addr(s_awaddr), .s_len(s_awlen), .s_id(s_awid),
    .m_valid(m_awvalid), .m_ready(m_awready), .m_addr(m_awaddr), .m_len(m_awlen), .m_id(m_awid)
  );

  axi_addr_fwd #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W)) u_ar (
    .clk(clk), .rst(rst), .block(rd_busy), .fire(rd_arm),
    .s_valid(s_arvalid), .s_ready(s_arready), .s_addr(s_araddr), .s_len(s_arlen), .s_id(s_arid),
    .m_valid(m_arvalid), .m_ready(m_arready), .m_addr(m_araddr), .m_len(m_arlen), .m_id(m_arid)
  );

  // write data: master is the source, slave the sink
  axi_beat_gate #(.DATA_W(DATA_W), .SIDE_W(STRB_W), .STALL(STALL_CYC), .XOR_MASK(DATA_XOR)) u_wgate (
    .clk(clk), .rst(rst), .arm(wr_arm), .busy(wr_busy),
    .up_valid(s_wvalid), .up_ready(s_wready), .up_data(s_wdata), .up_side(s_wstrb), .up_last(s_wlast),
    .dn_valid(m_wvalid), .dn_ready(m_wready), .dn_data(m_wdata), .dn_side(m_wstrb), .dn_last(m_wlast)
  );

  // read data: slave is the source, master the sink; ID and response travel with the word
  logic [RSIDE_W-1:0] r_side_dn;
  axi_beat_gate #(.DATA_W(DATA_W), .SIDE_W(RSIDE_W), .STALL(STALL_CYC), .XOR_MASK(DATA_XOR)) u_rgate (
    .clk(clk), .rst(rst), .arm(rd_arm), .busy(rd_busy),
    .up_valid(m_rvalid), .up_ready(m_rready), .up_data(m_rdata), .up_side({m_rid, m_rresp}), .up_last(m_rlast),
    .dn_valid(s_rvalid), .dn_ready(s_rready), .dn_data(s_rdata), .dn_side(r_side_dn), .dn_last(s_rlast)
  );
  assign s_rid   = r_side_dn[RSIDE_W-1:2];
  assign s_rresp = r_side_dn[1:0];

  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;
  assign s_bresp  = m_bresp;
  assign s_bid    = m_bid;
endmodule

// File: tb/sim_axi_beat_throttle.sv
module sim_axi_beat_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int STALL      = 15;
  localparam logic [63:0] MASK = 64'hA5A5_0000_FFFF_0001;
  // {direction (1 = read), beats, sink backpressure cycles}
  localparam logic [23:0] VECS [7] = '{
    {8'd0, 8'd1,  8'd0}, {8'd1, 8'd1,  8'd0}, {8'd0, 8'd3,  8'd2}, {8'd1, 8'd3,  8'd1},
    {8'd0, 8'd8,  8'd0}, {8'd1, 8'd64, 8'd0}, {8'd0, 8'd64, 8'd3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic s_awvalid = 0, s_awready, m_awvalid, m_awready = 0;
  logic [31:0] s_awaddr = 0, m_awaddr; logic [7:0] s_awlen = 0, m_awlen; logic [3:0] s_awid = 0, m_awid;
  logic s_wvalid = 0, s_wready, s_wlast = 0, m_wvalid, m_wready = 0, m_wlast;
  logic [63:0] s_wdata = 0, m_wdata; logic [7:0] s_wstrb = 0, m_wstrb;
  logic s_bvalid, s_bready = 0, m_bvalid = 0, m_bready;
  logic [1:0] s_bresp, m_bresp = 0; logic [3:0] s_bid, m_bid = 0;
  logic s_arvalid = 0, s_arready, m_arvalid, m_arready = 0;
  logic [31:0] s_araddr = 0, m_araddr; logic [7:0] s_arlen = 0, m_arlen; logic [3:0] s_arid = 0, m_arid;
  logic s_rvalid, s_rready = 0, s_rlast, m_rvalid = 0, m_rready, m_rlast = 0;
  logic [63:0] s_rdata, m_rdata = 0; logic [1:0] s_rresp, m_rresp = 0; logic [3:0] s_rid, m_rid = 0;

  int checks = 0, errors = 0;

  axi_beat_throttle #(.STALL_CYC(STALL), .DATA_XOR(MASK)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_word(int seed, int i);
    return {8'(seed), 24'(i), 32'(seed * 31 + i * 7) ^ 32'hC3C3_0F0F};
  endfunction

  task automatic write_burst(int seed, int beats, int rdly);
    @(negedge clk);
    s_awvalid = 1; s_awaddr = 32'(seed * 256); s_awlen = 8'(beats - 1); s_awid = 4'(seed); m_awready = 1;
    #1;
    check(m_awvalid && s_awready && m_awaddr == s_awaddr && m_awlen == s_awlen && m_awid == s_awid,
          "R1 aw pass", {m_awaddr, 24'(m_awlen), 4'(m_awid), 4'(m_awvalid)}, {s_awaddr, 24'(s_awlen), s_awid, 4'd1});
    @(posedge clk); @(negedge clk); #1;
    check(!m_awvalid && !s_awready, "R2 aw blocked", {m_awvalid, s_awready}, 0);
    s_awvalid = 0; m_awready = 0;
    for (int i = 0; i < beats; i++) begin
      int gap = 0; bit leak = 0;
      logic [63:0] d = beat_word(seed, i);
      s_wvalid = 1; s_wdata = d; s_wstrb = 8'(seed + i); s_wlast = (i == beats - 1);
      #1;
      while (!s_wready) begin @(negedge clk); #1; end
      @(posedge clk); @(negedge clk);
      s_wvalid = 0; #1;
      while (!m_wvalid && gap < 100) begin
        if (s_wready) leak = 1;
        gap++; @(negedge clk); #1;
      end
      check(gap == STALL && !leak, "R4 write stall", 64'(gap), 64'(STALL));
      for (int j = 0; j < rdly; j++) begin
        @(negedge clk); #1;
        check(m_wvalid && m_wdata == (d ^ MASK) && m_wlast == (i == beats - 1), "R5 write hold", m_wdata, d ^ MASK);
      end
      check(m_wdata == (d ^ MASK), "R6 write data", m_wdata, d ^ MASK);
      check(m_wstrb == 8'(seed + i) && m_wlast == (i == beats - 1), "R6 write strb/last",
            {m_wstrb, 7'd0, m_wlast}, {8'(seed + i), 7'd0, 1'(i == beats - 1)});
      m_wready = 1;
      @(posedge clk); @(negedge clk);
      m_wready = 0; s_wlast = 0;
    end
    #1;
    check(!s_wready && !m_wvalid, "R7 write disarm", {s_wready, m_wvalid}, 0);
    m_bvalid = 1; m_bresp = 2'(seed); m_bid = 4'(seed + 1); s_bready = 1; #1;
    check(s_bvalid && m_bready && s_bresp == m_bresp && s_bid == m_bid, "R8 b pass",
          {s_bvalid, m_bready, s_bresp, s_bid}, {1'b1, 1'b1, m_bresp, m_bid});
    @(posedge clk); @(negedge clk);
    m_bvalid = 0; s_bready = 0;
  endtask

  task automatic read_burst(int seed, int beats, int rdly);
    @(negedge clk);
    s_arvalid = 1; s_araddr = 32'(seed * 512); s_arlen = 8'(beats - 1); s_arid = 4'(seed); m_arready = 1;
    #1;
    check(m_arvalid && s_arready && m_araddr == s_araddr && m_arlen == s_arlen && m_arid == s_arid,
          "R1 ar pass", {m_araddr, 24'(m_arlen), 4'(m_arid), 4'(m_arvalid)}, {s_araddr, 24'(s_arlen), s_arid, 4'd1});
    @(posedge clk); @(negedge clk); #1;
    check(!m_arvalid && !s_arready, "R2 ar blocked", {m_arvalid, s_arready}, 0);
    s_arvalid = 0; m_arready = 0;
    for (int i = 0; i < beats; i++) begin
      int gap = 0; bit leak = 0;
      logic [63:0] d = beat_word(seed, i);
      m_rvalid = 1; m_rdata = d; m_rresp = 2'(i); m_rid = 4'(seed); m_rlast = (i == beats - 1);
      #1;
      while (!m_rready) begin @(negedge clk); #1; end
      @(posedge clk); @(negedge clk);
      m_rvalid = 0; #1;
      while (!s_rvalid && gap < 100) begin
        if (m_rready) leak = 1;
        gap++; @(negedge clk); #1;
      end
      check(gap == STALL && !leak, "R4 read stall", 64'(gap), 64'(STALL));
      for (int j = 0; j < rdly; j++) begin
        @(negedge clk); #1;
        check(s_rvalid && s_rdata == (d ^ MASK) && s_rlast == (i == beats - 1), "R5 read hold", s_rdata, d ^ MASK);
      end
      check(s_rdata == (d ^ MASK), "R6 read data", s_rdata, d ^ MASK);
      check(s_rid == 4'(seed) && s_rresp == 2'(i) && s_rlast == (i == beats - 1), "R6 read id/resp/last",
            {s_rid, s_rresp, s_rlast}, {4'(seed), 2'(i), 1'(i == beats - 1)});
      s_rready = 1;
      @(posedge clk); @(negedge clk);
      s_rready = 0; m_rlast = 0;
    end
    #1;
    check(!m_rready && !s_rvalid, "R7 read disarm", {m_rready, s_rvalid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(!s_wready && !m_wvalid && !m_rready && !s_rvalid, "R9 reset gates",
          {s_wready, m_wvalid, m_rready, s_rvalid}, 0);
    rst = 0;
    // R3: data with no address is ignored
    s_wvalid = 1; s_wdata = 64'h1234; s_wlast = 1; m_rvalid = 1; m_rdata = 64'h5678; m_rlast = 1;
    m_wready = 1; s_rready = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      check(!s_wready && !m_wvalid && !m_rready && !s_rvalid, "R3 unarmed data",
            {s_wready, m_wvalid, m_rready, s_rvalid}, 0);
    end
    s_wvalid = 0; s_wlast = 0; m_rvalid = 0; m_rlast = 0; m_wready = 0; s_rready = 0;
    foreach (VECS[v]) begin
      if (VECS[v][16]) read_burst(v + 3, int'(VECS[v][15:8]), int'(VECS[v][7:0]));
      else            write_burst(v + 3, int'(VECS[v][15:8]), int'(VECS[v][7:0]));
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule